// File: doc/BRIEF.md
# Bus-Controlled Successive-Approximation Conversion Controller

This block is the digital control of an 8-bit successive-approximation converter that sits on a microprocessor bus. Three bus controls decode each cycle: a read/write select and two active-low selects. When all three are low the cycle is a convert request. When the read/write select is high and both selects are low the cycle is a read. If either select is high the cycle does nothing. A convert request has to be held for a set number of clock cycles before it starts a conversion. At the start the block captures two mode bits, bipolar and two's-complement. It then searches for the code from the most significant bit down to the least. For each bit it drives a trial code toward an external DAC and comparator model, and it strobes the comparator.

While the search runs, the busy flag is high. During that time further convert requests are ignored, the conversion cannot be cut short, and the data bus enable cannot be raised. After the last bit the block keeps the code and lowers the busy flag. A read then drives the coded result with the data enable high. Raising either select drops the enable again. If the convert condition stays asserted, conversions run back to back. Once it is released, the conversion already running still completes.

Top module: `sar_bus_ctrl`

The controller is a four-state machine:
- ST_IDLE waits for an accepted start. It moves to ST_SET when a start is accepted.
- ST_SET drives the trial code so it can settle. It always moves to ST_STROBE.
- ST_STROBE pulses the comparator strobe and keeps or drops the bit under test. It returns to ST_SET while lower bits remain, and moves to ST_EOC after bit 0.
- ST_EOC is a single end-of-conversion cycle. It always returns to ST_IDLE.

## Requirements
- R1: A conversion starts only after read/write select, chip select and chip enable (`rw_i`, `cs_n_i`, `ce_n_i`) have all been low for START_HOLD consecutive clock edges. A shorter request leaves `status_o` low.
- R2: `data_oe_o` is high only when `rw_i`=1, `cs_n_i`=0 and `ce_n_i`=0, and no conversion is running. Raising either select removes the enable in the same cycle.
- R3: `status_o` rises in the cycle after the start is accepted. It stays high for exactly 2*WIDTH cycles, which are one set cycle and one strobe cycle per bit.
- R4: While `status_o` is high, convert requests and select changes neither restart nor abort the conversion. After `status_o` falls it stays low for at least one further cycle.
- R5: `data_oe_o` is never high while `status_o` is high.
- R6: The mode bits `bipolar_i` and `twos_i` are sampled when the start is accepted. Changes to them during the conversion do not affect the coded result.
- R7: Output coding:
  - In unipolar mode (`bipolar_i`=0) the raw code is output as straight binary, whatever `twos_i` is.
  - In bipolar mode with `twos_i`=0 the raw code is output as offset binary.
  - In bipolar mode with `twos_i`=1 the raw code is output with bit WIDTH-1 inverted, which gives two's complement.
- R8: The search runs from bit WIDTH-1 down to bit 0. In each step, `trial_o` holds the bits already decided, with the bit under test set and all lower bits clear, so the first trial is 0x80. `strobe_o` pulses in the second cycle of each step. The bit is cleared when `cmp_gt_i`=1 in that cycle. The raw result is the largest code not above the comparator's threshold.
- R9: If all three controls stay low, conversions repeat back to back. After release, the conversion in progress completes and no further one starts.
- R10: After reset, `status_o`, `strobe_o` and `data_oe_o` are low. A read before any conversion returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rw_i | input | 1 | Read/write select: 0 = convert, 1 = read |
| cs_n_i | input | 1 | Chip select, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| bipolar_i | input | 1 | Input format bit, sampled at start |
| twos_i | input | 1 | Output code bit, sampled at start |
| cmp_gt_i | input | 1 | Comparator result: trial code exceeds the input |
| trial_o | output | WIDTH | Trial code toward the DAC |
| strobe_o | output | 1 | Comparator strobe |
| status_o | output | 1 | High while a conversion runs |
| data_o | output | WIDTH | Coded result; zero while not enabled |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The search is first driven with directed threshold values at 0, 1, 0x7F, 0x80 and 0xFF. These show whether every bit decision and both ends of the range resolve correctly. Random thresholds are then run under all four mode combinations, and the mode bits are scrambled after each start. This tells a wrong coding table apart from a mode sampled at the wrong time.

Several control patterns separate the request handling from the search:
- A request one cycle short of the start limit.
- A request pulse and a select toggle in the middle of a conversion.
- A read held during the whole conversion.
- A convert condition held for many conversions.

Together they distinguish start filtering, abort immunity, read blocking and back-to-back operation.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SET,
        ST_STROBE,
        ST_EOC
    } sar_state_t;

    typedef struct packed {
        logic bipolar;
        logic twos;
    } conv_mode_t;
endpackage

// File: rtl/sar_start_filter.sv
module sar_start_filter #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic start_ok_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;

    // Counts consecutive request cycles, saturating one below the hold limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!req_i)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign start_ok_o = req_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_ctrl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok_i,
    input  conv_mode_t       mode_i,
    input  logic             cmp_gt_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             strobe_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] result_o,
    output conv_mode_t       mode_o
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

    sar_state_t       state_q, state_d;
    logic [IW-1:0]    idx_q;
    logic [WIDTH-1:0] code_q, result_q, bit_sel, trial, keep;
    conv_mode_t       mode_q;

    assign bit_sel = {{(WIDTH-1){1'b0}}, 1'b1} << idx_q;
    assign trial   = code_q | bit_sel;
    assign keep    = cmp_gt_i ? code_q : trial;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok_i) state_d = ST_SET;
            ST_SET:    state_d = ST_STROBE;
            ST_STROBE: state_d = (idx_q == '0) ? ST_EOC : ST_SET;
            ST_EOC:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= TOP_IDX;
            code_q   <= '0;
            result_q <= '0;
            mode_q   <= '0;
        end else if (state_q == ST_IDLE && start_ok_i) begin
            idx_q  <= TOP_IDX;
            code_q <= '0;
            mode_q <= mode_i;
        end else if (state_q == ST_STROBE) begin
            code_q <= keep;
            if (idx_q == '0)
                result_q <= keep;
            else
                idx_q <= idx_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        trial_o  = '0;
        strobe_o = 1'b0;
        busy_o   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_EOC: ;
            ST_SET: begin
                trial_o = trial;
                busy_o  = 1'b1;
            end
            ST_STROBE: begin
                trial_o  = trial;
                strobe_o = 1'b1;
                busy_o   = 1'b1;
            end
            default: ;
        endcase
    end

    assign result_o = result_q;
    assign mode_o   = mode_q;
endmodule

// File: rtl/sar_out_coder.sv
module sar_out_coder
    import sar_ctrl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] result_i,
    input  conv_mode_t       mode_i,
    input  logic             rd_sel_i,
    input  logic             busy_i,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe_o
);
    logic [WIDTH-1:0] flip;
    logic [WIDTH-1:0] coded;

    // Two's complement in bipolar mode: invert the sign bit of offset binary.
    assign flip      = {mode_i.bipolar & mode_i.twos, {(WIDTH-1){1'b0}}};
    assign coded     = result_i ^ flip;
    assign data_oe_o = rd_sel_i & ~busy_i;
    assign data_o    = data_oe_o ? coded : '0;
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int START_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rw_i,
    input  logic             cs_n_i,
    input  logic             ce_n_i,
    input  logic             bipolar_i,
    input  logic             twos_i,
    input  logic             cmp_gt_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             strobe_o,
    output logic             status_o,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe_o
);
    logic             selected, conv_req, rd_sel, start_ok, busy;
    logic [WIDTH-1:0] result;
    conv_mode_t       mode_in, mode_cap;

    assign selected = ~cs_n_i & ~ce_n_i;
    assign conv_req = selected & ~rw_i;
    assign rd_sel   = selected & rw_i;
    assign mode_in  = '{bipolar: bipolar_i, twos: twos_i};

    sar_start_filter #(.HOLD(START_HOLD)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (conv_req),
        .start_ok_o (start_ok)
    );

    sar_engine #(.WIDTH(WIDTH)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .mode_i     (mode_in),
        .cmp_gt_i   (cmp_gt_i),
        .trial_o    (trial_o),
        .strobe_o   (strobe_o),
        .busy_o     (busy),
        .result_o   (result),
        .mode_o     (mode_cap)
    );

    sar_out_coder #(.WIDTH(WIDTH)) u_code (
        .result_i  (result),
        .mode_i    (mode_cap),
        .rd_sel_i  (rd_sel),
        .busy_i    (busy),
        .data_o    (data_o),
        .data_oe_o (data_oe_o)
    );

    assign status_o = busy;
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rw_i,
    input logic             cs_n_i,
    input logic             ce_n_i,
    input logic [WIDTH-1:0] trial_o,
    input logic             strobe_o,
    input logic             status_o,
    input logic             data_oe_o
);
    localparam int BW = $clog2(2 * WIDTH + 2);
    localparam logic [BW-1:0] BUSY_LEN = BW'(2 * WIDTH);

    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (status_o)
            busy_cnt <= busy_cnt + 1'b1;
        else
            busy_cnt <= '0;
    end

    a_r5_no_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |-> !data_oe_o);

    a_r2_oe_decode: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (rw_i && !cs_n_i && !ce_n_i));

    a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |-> busy_cnt == BUSY_LEN);

    a_r4_gap_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |=> !status_o);

    a_r8_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> trial_o == {1'b1, {(WIDTH-1){1'b0}}});

    a_r8_strobe_alt: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> status_o);
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rw_i      (rw_i),
    .cs_n_i    (cs_n_i),
    .ce_n_i    (ce_n_i),
    .trial_o   (trial_o),
    .strobe_o  (strobe_o),
    .status_o  (status_o),
    .data_oe_o (data_oe_o)
);

// File: tb/sar_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sar_bus_ctrl_tb;
    localparam int W    = 8;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rw = 1'b1, cs_n = 1'b1, ce_n = 1'b1, bip = 1'b0, twos = 1'b0;
    logic [W-1:0] vin = '0;
    logic [W-1:0] trial, data;
    logic strobe, status, oe, cmp_gt;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    assign cmp_gt = trial > vin;

    sar_bus_ctrl #(.WIDTH(W), .START_HOLD(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .rw_i(rw), .cs_n_i(cs_n), .ce_n_i(ce_n),
        .bipolar_i(bip), .twos_i(twos), .cmp_gt_i(cmp_gt),
        .trial_o(trial), .strobe_o(strobe), .status_o(status),
        .data_o(data), .data_oe_o(oe)
    );

    function automatic logic [W-1:0] exp_code(logic [W-1:0] v, logic b, logic t);
        return (b && t) ? (v ^ {1'b1, {(W-1){1'b0}}}) : v;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Wait through the busy period, counting high cycles seen at negedges.
    task automatic wait_done(output int n);
        n = 0;
        while (status && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_quiet(input string tag);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!status, tag, status, 0);
        end
    endtask

    // One conversion with read held; poke adds mid-conversion disturbances.
    task automatic convert(input logic [W-1:0] v, input logic b, input logic t, input bit poke);
        int n;
        @(negedge clk);
        vin = v; bip = b; twos = t; rw = 1'b0; cs_n = 1'b0; ce_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        chk(status == 1'b1, "R1 start after hold", status, 1);
        chk(trial == 8'h80 && !strobe, "R8 first trial", trial, 8'h80);
        rw = 1'b1;
        bip = ~b; twos = ~t;                    // R6: scramble after capture
        @(negedge clk);
        chk(strobe == 1'b1, "R8 strobe in 2nd cycle", strobe, 1);
        #2 chk(!oe, "R5 read blocked while busy", oe, 0);
        n = 2;
        while (status && n < 200) begin
            if (poke && n == 5)  rw = 1'b0;     // R4: new request mid-conversion
            if (poke && n == 10) rw = 1'b1;
            if (poke && n == 12) cs_n = 1'b1;   // R4: attempted abort
            if (poke && n == 13) cs_n = 1'b0;
            @(negedge clk);
            if (status) n++;
        end
        chk(n == 2 * W, "R3 busy length", n, 2 * W);
        #2;
        chk(oe == 1'b1, "R2 read enabled after eoc", oe, 1);
        chk(data == exp_code(v, b, t), "R7 coded result", data, exp_code(v, b, t));
        cs_n = 1'b1;
        #2 chk(!oe && data == '0, "R2 select high ends read", oe, 0);
        if (poke) check_quiet("R4 no restart");
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rises, n;
        logic prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!status && !strobe && !oe, "R10 reset outputs", {status, strobe, oe}, 0);
        cs_n = 1'b0; ce_n = 1'b0; rw = 1'b1;
        #2 chk(oe && data == '0, "R10 initial read", data, 0);
        cs_n = 1'b1;

        // R1: one cycle short
        @(negedge clk);
        rw = 1'b0; cs_n = 1'b0; ce_n = 1'b0;
        repeat (HOLD - 1) @(negedge clk);
        rw = 1'b1;
        check_quiet("R1 short request");
        ce_n = 1'b1;
        #2 chk(!oe, "R2 chip enable high blocks read", oe, 0);
        ce_n = 1'b0;

        // R8 directed thresholds, R7 coding
        convert(8'h00, 1'b0, 1'b0, 1'b0);
        convert(8'hFF, 1'b0, 1'b1, 1'b0);
        convert(8'h01, 1'b1, 1'b0, 1'b0);
        convert(8'h80, 1'b1, 1'b1, 1'b0);
        convert(8'h7F, 1'b1, 1'b1, 1'b0);
        // R4 disturbances
        convert(8'h5A, 1'b0, 1'b0, 1'b1);

        // R9 back-to-back
        @(negedge clk);
        vin = 8'hC3; bip = 1'b1; twos = 1'b1;
        rw = 1'b0; cs_n = 1'b0; ce_n = 1'b0;
        rises = 0; prev = status;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (status && !prev) rises++;
            prev = status;
        end
        chk(rises >= 3, "R9 repeated conversions", rises, 3);
        while (!status) @(negedge clk);
        rw = 1'b1;
        wait_done(n);
        #2 chk(oe && data == 8'h43, "R9 final result", data, 8'h43);
        check_quiet("R9 stop after release");
        cs_n = 1'b1;

        // Random conversions
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] v;
            logic b, t;
            v = W'($urandom);
            b = 1'($urandom);
            t = 1'($urandom);
            convert(v, b, t, 1'($urandom_range(0, 3) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule